// File: doc/BRIEF.md
# Floating-point compare condition-code unit

This block compares two IEEE-754 operands and records the outcome as a 2-bit condition code in one of four condition fields of a 64-bit floating-point status register. A compare is requested by raising a valid strobe for one cycle, together with an operation code that selects the precision (single or double) and the variant (quiet or signaling). The updated status register appears on the clock edge that samples the strobe.

The quiet variants report unordered operands as a code of their own. The signaling variants raise an IEEE exception flag on any NaN and leave the register untouched. Quad-precision compare codes do no arithmetic: they only raise an "other exception" flag. Any other code raises an unimplemented-operation flag. The three flags are one-cycle pulses that register together with the status update.

Top module: `fcmp_cc_unit`

## Requirements
- R1: For ordered operands the code written is 0 when equal, 1 when operand A is less than operand B, and 2 when A is greater.
- R2: In the quiet variants (op 0x51 single, 0x52 double), a NaN in either operand (exponent all ones, fraction nonzero) writes code 3.
- R3: In the signaling variants (op 0x54 single, 0x55 double), a NaN in either operand pulses ieee_exc_o and leaves fsr_o unchanged; with ordered operands they write the same codes as the quiet variants.
- R4: Selector value 0 writes the code into fsr_o bits 11:10.
- R5: Selector value n of 1 to 3 writes the code into fsr_o bits 2n+31:2n+30, that is 33:32, 35:34 or 37:36.
- R6: Single-precision compares use only bits 31:0 of each operand bus; bits 63:32 have no effect.
- R7: Op codes 0x53 and 0x56 pulse other_exc_o and leave fsr_o unchanged.
- R8: Any op code other than 0x51 to 0x56 pulses unimpl_o and leaves fsr_o unchanged; at most one flag is high at a time.
- R9: Positive and negative zero compare as equal; other values are ordered by sign and then magnitude, so that negative values of larger magnitude are smaller and infinities are ordered.
- R10: A write changes only the two bits of the selected field; all other status bits are kept.
- R11: fsr_o is zero after reset, updates on the rising clock edge that samples valid_i high, keeps its value while valid_i is low, and flags are low in any cycle that follows a cycle without valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare request strobe |
| opf_i | input | 9 | Operation code |
| fcc_sel_i | input | 2 | Condition field selector |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| fsr_o | output | 64 | Floating-point status register |
| ieee_exc_o | output | 1 | IEEE exception flag (signaling compare saw a NaN) |
| other_exc_o | output | 1 | Other exception flag (quad compare) |
| unimpl_o | output | 1 | Unimplemented operation flag |

## Verification
Compares are driven with pairs that are equal, less and greater in both precisions, with mixed signs, both negative, signed zeros and infinities, so that a bare unsigned compare or a missing sign reversal gives a wrong code. NaN pairs are run through quiet and signaling codes to tell the unordered code apart from the exception path, and single compares carry junk in the upper operand bits that would look like a NaN to a double compare. Each selector value is written with distinct codes while earlier fields stay set, which separates a wrong field position from lost neighbouring bits, and quad, unknown and idle cycles confirm the register holds.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned OPF_W  = 9;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned FCC_W  = 2;
  localparam int unsigned MAG_W  = DATA_W - 1;
  localparam int unsigned POS_W  = $clog2(DATA_W);

  localparam logic [OPF_W-1:0] OPF_CMP_QS = 9'h051;
  localparam logic [OPF_W-1:0] OPF_CMP_QD = 9'h052;
  localparam logic [OPF_W-1:0] OPF_CMP_QQ = 9'h053;
  localparam logic [OPF_W-1:0] OPF_CMP_SS = 9'h054;
  localparam logic [OPF_W-1:0] OPF_CMP_SD = 9'h055;
  localparam logic [OPF_W-1:0] OPF_CMP_SQ = 9'h056;

  localparam int unsigned FIELD0_LSB = 10;
  localparam int unsigned FIELDN_BASE = 30;

  typedef enum logic [FCC_W-1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fcc_e;

  typedef struct packed {
    logic             is_nan;
    logic             is_zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } fp_class_t;

  typedef struct packed {
    logic is_cmp;
    logic is_double;
    logic is_signal;
    logic is_quad;
    logic is_unimpl;
  } op_dec_t;

  function automatic logic [POS_W-1:0] field_lsb(input logic [SEL_W-1:0] sel);
    logic [POS_W-1:0] r;
    if (sel == '0) r = POS_W'(FIELD0_LSB);
    else           r = POS_W'(FIELDN_BASE + 2 * int'(sel));
    return r;
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned FMT_W = EXP_W + FRAC_W + 1
) (
  input  logic [FMT_W-1:0] bits_i,
  output fp_class_t        cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = bits_i[FMT_W-2 -: EXP_W];
  assign frac_f = bits_i[FRAC_W-1:0];

  always_comb begin
    cls_o.sign    = bits_i[FMT_W-1];
    cls_o.is_nan  = (&exp_f) && (|frac_f);
    cls_o.is_zero = ~|bits_i[FMT_W-2:0];
    cls_o.mag     = MAG_W'(bits_i[FMT_W-2:0]);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  fp_class_t a_i,
  input  fp_class_t b_i,
  output fcc_e      cc_o
);
  logic mag_lt, mag_gt;

  assign mag_lt = a_i.mag < b_i.mag;
  assign mag_gt = a_i.mag > b_i.mag;

  always_comb begin
    if (a_i.is_nan || b_i.is_nan)       cc_o = FCC_UN;
    else if (a_i.is_zero && b_i.is_zero) cc_o = FCC_EQ;
    else if (a_i.sign != b_i.sign)       cc_o = a_i.sign ? FCC_LT : FCC_GT;
    else if (!mag_lt && !mag_gt)         cc_o = FCC_EQ;
    else if (a_i.sign)                   cc_o = mag_lt ? FCC_GT : FCC_LT;
    else                                 cc_o = mag_lt ? FCC_LT : FCC_GT;
  end
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [OPF_W-1:0] opf_i,
  output op_dec_t          dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (opf_i)
      OPF_CMP_QS: dec_o.is_cmp = 1'b1;
      OPF_CMP_QD: begin dec_o.is_cmp = 1'b1; dec_o.is_double = 1'b1; end
      OPF_CMP_SS: begin dec_o.is_cmp = 1'b1; dec_o.is_signal = 1'b1; end
      OPF_CMP_SD: begin
        dec_o.is_cmp    = 1'b1;
        dec_o.is_double = 1'b1;
        dec_o.is_signal = 1'b1;
      end
      OPF_CMP_QQ, OPF_CMP_SQ: dec_o.is_quad = 1'b1;
      default: dec_o.is_unimpl = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPF_W-1:0]  opf_i,
  input  logic [SEL_W-1:0]  fcc_sel_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] fsr_o,
  output logic              ieee_exc_o,
  output logic              other_exc_o,
  output logic              unimpl_o
);
  localparam int unsigned N_OPS  = 2;
  localparam int unsigned SGL_W  = 32;

  op_dec_t   dec;
  fp_class_t cls_s [N_OPS];
  fp_class_t cls_d [N_OPS];
  fp_class_t cls   [N_OPS];
  fcc_e      cc;

  logic [DATA_W-1:0] opnd [N_OPS];
  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  fcmp_decode i_decode (.opf_i(opf_i), .dec_o(dec));

  for (genvar g = 0; g < N_OPS; g++) begin : g_opnd
    fcmp_classify #(.EXP_W(8), .FRAC_W(23)) i_cls_s (
      .bits_i(opnd[g][SGL_W-1:0]),
      .cls_o (cls_s[g])
    );
    fcmp_classify #(.EXP_W(11), .FRAC_W(52)) i_cls_d (
      .bits_i(opnd[g]),
      .cls_o (cls_d[g])
    );
    assign cls[g] = dec.is_double ? cls_d[g] : cls_s[g];
  end

  fcmp_order i_order (.a_i(cls[0]), .b_i(cls[1]), .cc_o(cc));

  logic ieee_c, other_c, unimpl_c, fault_c, wr_en;
  logic [POS_W-1:0]  lsb;
  logic [DATA_W-1:0] mask, fsr_d, fsr_q;

  assign ieee_c   = valid_i && dec.is_signal && (cls[0].is_nan || cls[1].is_nan);
  assign other_c  = valid_i && dec.is_quad;
  assign unimpl_c = valid_i && dec.is_unimpl;
  assign fault_c  = ieee_c || other_c || unimpl_c;
  assign wr_en    = valid_i && dec.is_cmp && !ieee_c;

  assign lsb   = field_lsb(fcc_sel_i);
  assign mask  = DATA_W'({FCC_W{1'b1}}) << lsb;
  assign fsr_d = (fsr_q & ~mask) | (DATA_W'(cc) << lsb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q       <= '0;
      ieee_exc_o  <= 1'b0;
      other_exc_o <= 1'b0;
      unimpl_o    <= 1'b0;
    end else begin
      if (wr_en) fsr_q <= fsr_d;
      ieee_exc_o  <= ieee_c;
      other_exc_o <= other_c;
      unimpl_o    <= unimpl_c;
    end
  end

  assign fsr_o = fsr_q;

  assert_hold_on_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fault_c) |=> $stable(fsr_o));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(fsr_o) && !ieee_exc_o && !other_exc_o && !unimpl_o));

  assert_outside_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (((fsr_o ^ $past(fsr_o)) & ~$past(mask)) == '0));

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ieee_exc_o, other_exc_o, unimpl_o}));

  assert_quiet_nan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (cls[0].is_nan || cls[1].is_nan)) |=>
      (((fsr_o >> $past(lsb)) & DATA_W'(3)) == DATA_W'(3)));
endmodule

// File: tb/test_fcmp_cc_unit.sv
`timescale 1ns/1ps
module test_fcmp_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [8:0]  opf = '0;
  logic [1:0]  sel = '0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] fsr;
  logic        ieee, other, unimpl;

  int checks = 0, errors = 0;

  typedef struct {
    logic [63:0] fsr;
    logic [2:0]  flags;
    string       tag;
  } exp_t;
  exp_t sbq[$];
  logic [63:0] model_fsr = '0;

  always #4 clk = ~clk;

  fcmp_cc_unit i_fcmp_cc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opf_i(opf),
    .fcc_sel_i(sel), .op_a_i(a), .op_b_i(b), .fsr_o(fsr),
    .ieee_exc_o(ieee), .other_exc_o(other), .unimpl_o(unimpl)
  );

  function automatic int lsb_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 32;
      2'd2: return 34;
      default: return 36;
    endcase
  endfunction

  // flags: {ieee, other, unimpl}; cc ignored unless flags == 0 and valid compare
  task automatic drive(input logic [8:0] o, input logic [1:0] s, input logic [63:0] x,
                       input logic [63:0] y, input logic [1:0] cc, input logic [2:0] fl,
                       input string tag);
    exp_t e;
    @(negedge clk);
    valid = 1'b1; opf = o; sel = s; a = x; b = y;
    if (fl == 3'b000) begin
      model_fsr[lsb_of(s)+:2] = cc;
    end
    e.fsr = model_fsr; e.flags = fl; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    valid = 1'b0; opf = 9'h051; a = 64'h7FF8_0000_0000_0000; b = '0; sel = 2'd3;
    e.fsr = model_fsr; e.flags = 3'b000; e.tag = tag;
    sbq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (fsr !== e.fsr || {ieee, other, unimpl} !== e.flags) begin
          errors++;
          $display("FAIL %s: fsr=%h flags=%b expected fsr=%h flags=%b",
                   e.tag, fsr, {ieee, other, unimpl}, e.fsr, e.flags);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [63:0] J  = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] S1 = 64'h3F80_0000, S2 = 64'h4000_0000;
  localparam logic [63:0] SN1 = 64'hBF80_0000, SN2 = 64'hC000_0000;
  localparam logic [63:0] SZ = 64'h0, SNZ = 64'h8000_0000;
  localparam logic [63:0] SNAN = 64'h7FC0_0000, SINF = 64'h7F80_0000, SNINF = 64'hFF80_0000;
  localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] DN1 = 64'hBFF0_0000_0000_0000, DN2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] DNZ = 64'h8000_0000_0000_0000, DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DINF = 64'h7FF0_0000_0000_0000;

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (fsr !== '0 || {ieee, other, unimpl} !== 3'b000) begin
      errors++;
      $display("FAIL R11 reset: fsr=%h flags=%b expected 0", fsr, {ieee, other, unimpl});
    end
    rst_n = 1'b1;
    idle("R11 idle after reset");
    // R1 basic ordering, single and double, field 0 (R4)
    drive(9'h051, 2'd0, S1, S2, 2'd1, 3'b000, "R1 single lt / R4");
    drive(9'h051, 2'd0, S2, S1, 2'd2, 3'b000, "R1 single gt / R4");
    drive(9'h051, 2'd0, S1, S1, 2'd0, 3'b000, "R1 single eq / R4");
    drive(9'h052, 2'd0, D2, D1, 2'd2, 3'b000, "R1 double gt");
    drive(9'h052, 2'd0, D1, D2, 2'd1, 3'b000, "R1 double lt");
    // R9 signs, zeros, infinities
    drive(9'h051, 2'd0, SN1, S1, 2'd1, 3'b000, "R9 neg vs pos");
    drive(9'h051, 2'd0, SN2, SN1, 2'd1, 3'b000, "R9 both neg lt");
    drive(9'h052, 2'd0, DN1, DN2, 2'd2, 3'b000, "R9 both neg gt");
    drive(9'h051, 2'd0, SNZ, SZ, 2'd0, 3'b000, "R9 -0 == +0 single");
    drive(9'h052, 2'd0, 64'h0, DNZ, 2'd0, 3'b000, "R9 +0 == -0 double");
    drive(9'h051, 2'd0, SINF, S2, 2'd2, 3'b000, "R9 +inf gt");
    drive(9'h051, 2'd0, SNINF, SN2, 2'd1, 3'b000, "R9 -inf lt");
    drive(9'h052, 2'd0, DINF, DINF, 2'd0, 3'b000, "R9 inf eq");
    // R6 single ignores upper half
    drive(9'h051, 2'd0, J | S1, J | S2, 2'd1, 3'b000, "R6 upper bits ignored");
    drive(9'h054, 2'd0, J | S2, J | S1, 2'd2, 3'b000, "R6 signaling single upper ignored");
    // R5 / R10 fields 1..3 with distinct codes, others preserved
    drive(9'h052, 2'd1, D1, D2, 2'd1, 3'b000, "R5 field1 / R10");
    drive(9'h052, 2'd2, D2, D1, 2'd2, 3'b000, "R5 field2 / R10");
    drive(9'h051, 2'd3, SNAN, S1, 2'd3, 3'b000, "R5 field3 / R2 quiet single nan");
    drive(9'h052, 2'd1, D1, DNAN, 2'd3, 3'b000, "R2 quiet double nan field1");
    drive(9'h051, 2'd0, S2, S2, 2'd0, 3'b000, "R10 field0 rewrite keeps others");
    // R3 signaling
    drive(9'h055, 2'd2, DNAN, D1, 2'd0, 3'b100, "R3 signaling double nan");
    drive(9'h054, 2'd3, S1, SNAN, 2'd0, 3'b100, "R3 signaling single nan");
    drive(9'h055, 2'd2, D1, D1, 2'd0, 3'b000, "R3 signaling double eq");
    drive(9'h054, 2'd3, SN1, S1, 2'd1, 3'b000, "R3 signaling single lt");
    // R7 quad, R8 unknown
    drive(9'h053, 2'd1, D1, D2, 2'd0, 3'b010, "R7 quad quiet");
    drive(9'h056, 2'd0, D2, D1, 2'd0, 3'b010, "R7 quad signaling");
    drive(9'h050, 2'd0, D1, D2, 2'd0, 3'b001, "R8 unknown 0x50");
    drive(9'h057, 2'd1, D1, D2, 2'd0, 3'b001, "R8 unknown 0x57");
    drive(9'h151, 2'd2, S1, S2, 2'd0, 3'b001, "R8 unknown 0x151");
    idle("R11 idle hold");
    idle("R11 idle hold 2");
    drive(9'h051, 2'd1, S1, S2, 2'd1, 3'b000, "R11 update after idle");
    idle("R11 flags clear");
    idle("drain");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule